// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Indicator

This block compares two divided clock signals that are already synchronous to a sampling clock: a reference-divider output and a feedback-divider output. A rising edge on either signal raises that signal's pending flag. When both flags are up, they clear together on the following clock. The two flags drive a pair of correction outputs meant for an external charge pump. Their width encodes the phase error, and which output fires encodes its sign.

One polarity input sets the sense of the comparison. When it is high, a leading reference drives the up output. When it is low, the mapping is swapped so the same block suits a loop whose oscillator has a negative tuning slope. The same input also picks which divided signal is copied to a monitor output. A lock flag rises once eight comparison periods in a row have had their two edges at most one clock apart. It drops as soon as a period overruns that window.

Top module: `phase_lock_detector`

## Requirements
- R1: While reset is high and on the first cycle after it is released, up, dn and lock are all low.
- R2: With pol high, a rising edge of ref_in sampled at a clock edge makes up high from that edge on. It stays high until both flags are set.
- R3: With pol high, a rising edge of div_in sampled at a clock edge makes dn high from that edge on. It stays high until both flags are set.
- R4: When both pending flags are high at a clock edge, both are low after that edge, unless a new rising edge arrives at that same edge.
- R5: With pol low, the mapping is swapped: the ref_in flag drives dn and the div_in flag drives up.
- R6: mon follows ref_in combinationally when pol is high, and follows div_in when pol is low.
- R7: A comparison period counts as good when its lagging edge is sampled no more than one clock after its leading edge. lock goes high at the clock edge that sees both flags set in the eighth good period in a row. It stays high through further good periods.
- R8: When one flag has been high alone for more than one clock, lock goes low at that clock edge. This is two edges after the leading edge was sampled. The count of good periods restarts from zero.
- R9: Rising edges on both inputs sampled at the same clock edge give up and dn high together for exactly one cycle.
- R10: A signal that stays high after its rising edge does not set its flag again once the flags have cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference divider output, synchronous to clk |
| div_in | input | 1 | Feedback divider output, synchronous to clk |
| pol | input | 1 | Polarity select; high = normal sense, low = inverted |
| up | output | 1 | Pump-up correction request |
| dn | output | 1 | Pump-down correction request |
| lock | output | 1 | High while the loop is judged locked |
| mon | output | 1 | Copy of ref_in (pol high) or div_in (pol low) |

## Verification
The latency of each output is fixed. mon changes in the same cycle as its input. A flag shows on up or dn after the first clock edge that samples the rising input. Both flags are gone one edge after the edge that sees them together. lock changes at the edge that sees both flags set, or two edges after the leading edge in an overrun period. The driver works out, for every cycle of a twelve-cycle comparison period, the values of up, dn, lock and mon, and tags each value with its cycle number. The monitor samples 2 ns after each falling edge and compares only the entry whose timestamp matches the current cycle. Periods vary lead direction, gap (0 to 4 clocks) and polarity, so lock rises, holds, drops and recovers.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int CH_REF = 0;
    localparam int CH_DIV = 1;
    localparam int N_CH   = 2;

    typedef struct packed {
        logic div_f;
        logic ref_f;
    } pfd_flags_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_drive_t;

    typedef enum logic [1:0] {
        PAIR_IDLE = 2'd0,
        PAIR_ONE  = 2'd1,
        PAIR_BOTH = 2'd2
    } pair_state_e;

    function automatic pair_state_e classify(pfd_flags_t f);
        if (f.ref_f && f.div_f)
            return PAIR_BOTH;
        else if (f.ref_f || f.div_f)
            return PAIR_ONE;
        else
            return PAIR_IDLE;
    endfunction

    function automatic pfd_drive_t steer(pfd_flags_t f, logic pos);
        pfd_drive_t d;
        d.up = pos ? f.ref_f : f.div_f;
        d.dn = pos ? f.div_f : f.ref_f;
        return d;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   rise,
    output pfd_flags_t        flags_q
);
    pfd_flags_t flags_d;

    always_comb begin
        if (classify(flags_q) == PAIR_BOTH) begin
            flags_d.ref_f = rise[CH_REF];
            flags_d.div_f = rise[CH_DIV];
        end else begin
            flags_d.ref_f = flags_q.ref_f | rise[CH_REF];
            flags_d.div_f = flags_q.div_f | rise[CH_DIV];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
    import pfd_pkg::*;
#(
    parameter int LOCK_CNT = 8,
    parameter int WINDOW   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  pfd_flags_t flags,
    output logic       lock
);
    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam int EW = $clog2(WINDOW + 2);
    localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_CNT);
    localparam logic [EW-1:0] WIN      = EW'(WINDOW);

    logic [EW-1:0] err_q;
    logic [GW-1:0] good_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            good_q <= '0;
        end else begin
            unique case (classify(flags))
                PAIR_BOTH: begin
                    err_q <= '0;
                    if (err_q <= WIN && good_q != GOOD_MAX)
                        good_q <= good_q + 1'b1;
                end
                PAIR_ONE: begin
                    if (err_q <= WIN)
                        err_q <= err_q + 1'b1;
                    if (err_q >= WIN)
                        good_q <= '0;
                end
                default: begin
                    err_q <= '0;
                end
            endcase
        end
    end

    assign lock = (good_q == GOOD_MAX);
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import pfd_pkg::*;
#(
    parameter int LOCK_CNT = 8,
    parameter int WINDOW   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic div_in,
    input  logic pol,
    output logic up,
    output logic dn,
    output logic lock,
    output logic mon
);
    logic [N_CH-1:0] sig_vec;
    logic [N_CH-1:0] rise_vec;
    pfd_flags_t      flags;
    pfd_drive_t      drive;

    always_comb begin
        sig_vec         = '0;
        sig_vec[CH_REF] = ref_in;
        sig_vec[CH_DIV] = div_in;
    end

    pfd_edge_det #(.N(N_CH)) u_edge (
        .clk  (clk),
        .sig  (sig_vec),
        .rise (rise_vec)
    );

    pfd_core u_core (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise_vec),
        .flags_q (flags)
    );

    pfd_lock_det #(.LOCK_CNT(LOCK_CNT), .WINDOW(WINDOW)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .lock  (lock)
    );

    assign drive = steer(flags, pol);
    assign up    = drive.up;
    assign dn    = drive.dn;
    assign mon   = pol ? ref_in : div_in;
endmodule

// File: rtl/phase_lock_detector_chk.sv
module phase_lock_detector_chk (
    input logic clk,
    input logic rst,
    input logic ref_in,
    input logic div_in,
    input logic pol,
    input logic up,
    input logic dn,
    input logic lock
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up && !dn && !lock));

    // R2
    ref_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_in && !$past(ref_in)) |=> (pol ? up : dn));

    // R3
    div_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (div_in && !$past(div_in)) |=> (pol ? dn : up));

    // R4
    pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (up && dn && !(ref_in && !$past(ref_in)) && !(div_in && !$past(div_in)))
        |=> (!up && !dn));

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(up && dn));

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((up ^ dn) && $past(up ^ dn)) |=> !lock);
endmodule

bind phase_lock_detector phase_lock_detector_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_in),
    .div_in (div_in),
    .pol    (pol),
    .up     (up),
    .dn     (dn),
    .lock   (lock)
);

// File: tb/phase_lock_detector_bench.sv
module phase_lock_detector_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic div_in = 1'b0;
    logic pol = 1'b1;
    logic up, dn, lock, mon;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int PERIOD = 12;
    localparam int LOW_AT = 6;
    localparam int NPER   = 24;

    typedef struct {
        int    cyc;
        bit    up;
        bit    dn;
        bit    lk;
        bit    mon;
        string rup;
        string rdn;
        string rlk;
    } item_t;

    item_t sbq[$];

    // bench model of the lock run
    int  good_run = 0;
    bit  lock_model = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_lock_detector u_phase_lock_detector (
        .clk (clk), .rst (rst), .ref_in (ref_in), .div_in (div_in),
        .pol (pol), .up (up), .dn (dn), .lock (lock), .mon (mon)
    );

    task automatic check(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
        end
    endtask

    // monitor: pops the item due in the current cycle
    always @(negedge clk) begin
        #2;
        while (sbq.size() > 0 && sbq[0].cyc == cyc) begin
            item_t it;
            it = sbq.pop_front();
            check(it.rup, "up", up, it.up);
            check(it.rdn, "dn", dn, it.dn);
            check(it.rlk, "lock", lock, it.lk);
            check("R6", "mon", mon, it.mon);
        end
    end

    // driver: one comparison period; pushes its expected items, then drives
    task automatic run_period(input bit pol_v, input bit fr_lead, input int g);
        int  n, t_r, t_d, ev;
        bit  good, prev_lk, new_lk;
        @(negedge clk);
        n   = cyc;
        pol = pol_v;
        t_r = fr_lead ? n : n + g;
        t_d = fr_lead ? n + g : n;
        good = (g <= 1);
        prev_lk = lock_model;
        if (good) begin
            good_run = (good_run < 8) ? good_run + 1 : 8;
        end else begin
            good_run = 0;
        end
        new_lk = (good_run >= 8);
        lock_model = new_lk;
        ev = good ? n + g + 2 : n + 3;
        for (int c = n; c < n + PERIOD; c++) begin
            item_t it;
            bit fr_f, fd_f;
            fr_f = (c >= t_r + 1) && (c <= n + g + 1);
            fd_f = (c >= t_d + 1) && (c <= n + g + 1);
            it.cyc = c;
            it.up  = pol_v ? fr_f : fd_f;
            it.dn  = pol_v ? fd_f : fr_f;
            it.lk  = (c >= ev) ? new_lk : prev_lk;
            it.mon = pol_v ? ((c >= t_r) && (c < n + LOW_AT))
                           : ((c >= t_d) && (c < n + LOW_AT));
            if (c == n + g + 2)      begin it.rup = "R4";  it.rdn = "R4";  end
            else if (c > n + g + 2)  begin it.rup = "R10"; it.rdn = "R10"; end
            else if (g == 0)         begin it.rup = "R9";  it.rdn = "R9";  end
            else if (!pol_v)         begin it.rup = "R5";  it.rdn = "R5";  end
            else                     begin it.rup = "R2";  it.rdn = "R3";  end
            it.rlk = good ? "R7" : "R8";
            sbq.push_back(it);
        end
        if (fr_lead || g == 0) ref_in = 1'b1;
        if (!fr_lead || g == 0) div_in = 1'b1;
        for (int k = 0; k < g; k++) @(negedge clk);
        ref_in = 1'b1;
        div_in = 1'b1;
        while (cyc != n + LOW_AT) @(negedge clk);
        ref_in = 1'b0;
        div_in = 1'b0;
        while (cyc != n + PERIOD - 1) @(negedge clk);
    endtask

    bit pol_list[NPER]  = '{1,1,1,0,0,0,1,1, 0,1, 1,1,1, 0,0, 1,0,1,0,1,0,1,0, 1};
    bit lead_list[NPER] = '{1,1,0,1,0,1,0,1, 1,1, 0,0,0, 0,1, 1,1,0,0,1,1,0,0, 0};
    int gap_list[NPER]  = '{0,1,1,0,1,1,0,1, 1,3, 1,1,1, 2,4, 0,1,1,0,1,0,1,1, 4};

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        #2;
        check("R1", "up in reset", up, 1'b0);
        check("R1", "dn in reset", dn, 1'b0);
        check("R1", "lock in reset", lock, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", "up after reset", up, 1'b0);
        check("R1", "dn after reset", dn, 1'b0);
        check("R1", "lock after reset", lock, 1'b0);
        for (int p = 0; p < NPER; p++) begin
            run_period(pol_list[p], lead_list[p], gap_list[p]);
        end
        @(negedge clk);
        #4;
        if (sbq.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule